// File: doc/BRIEF.md
# Stack-Relative Operand Address Generator

This block turns the 9-bit register operand selector of an 8-bit microcontroller instruction into a flat data-space address. The selector either names one of 128 special-purpose registers or 128 global registers directly, or it picks a stack-relative form. In the stack-relative form a 7-bit unsigned offset from the instruction is added to a 16-bit data stack pointer. The flat data space places the special-purpose registers at 0x000..0x07F, the global registers at 0x080..0x0FF, and a 3840-byte data memory at 0x100..0xFFF.

The block owns the data stack pointer. The pointer is kept as a high byte register and a low byte register, and each byte can be written directly. A push addresses the stack item at the current pointer and then decrements the pointer. A pop increments the pointer first and addresses the stack item at the incremented value. In the cycle of a pop, a stack-relative operand is still formed from the pointer as it was before the increment. The stack address is driven on its own output, so the core can reach an operand and the stack item in the same cycle.

Subroutine call and return use a separate hardware stack, and nothing in that path reaches this pointer. The address outputs are combinational from the current pointer and the current inputs. The pointer changes only at the clock edge.

Top module: `sp_operand_addr`

## Requirements
- R1: While reset is asserted and right after it is released, the pointer reads the parameter RESET_SP (default 0x0FFF).
- R2: With selector bit 8 clear and bit 7 clear, operandAddr is bits 6:0 zero-extended, and opKind is 0 (special-purpose register).
- R3: With selector bit 8 clear and bit 7 set, operandAddr is 0x080 plus bits 6:0, and opKind is 1 (global register).
- R4: With selector bit 8 set, operandAddr is the current pointer plus the unsigned offset in bits 6:0, taken modulo 2^16. Bit 7 is ignored and opKind is 2 (stack-relative).
- R5: stackOp code 1 (push) drives stackAddr with the current pointer, and at the next clock edge the pointer becomes pointer-1 modulo 2^16.
- R6: stackOp code 2 (pop) drives stackAddr with pointer+1, and at the next clock edge the pointer becomes pointer+1. In that same cycle a stack-relative operandAddr still uses the pointer before the increment.
- R7: stackOp code 0 (none) and code 3 (reserved) leave the pointer unchanged, and stackAddr equals the pointer.
- R8: wrHi loads wrData into pointer bits 15:8 and wrLo loads wrData into pointer bits 7:0, both at the next clock edge. When both are set, both bytes take wrData.
- R9: A direct byte write in the same cycle as a push or pop wins. The automatic update is dropped for the whole pointer, and a byte that is not written keeps its value.
- R10: The pointer wraps: a pop at 0xFFFF gives 0x0000, and a push at 0x0000 gives 0xFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| opField | input | 9 | Operand selector from the instruction word |
| stackOp | input | 2 | Stack operation: 0 none, 1 push, 2 pop, 3 reserved (none) |
| wrHi | input | 1 | Load wrData into the pointer high byte |
| wrLo | input | 1 | Load wrData into the pointer low byte |
| wrData | input | 8 | Data for direct pointer byte writes |
| operandAddr | output | 16 | Resolved operand address |
| opKind | output | 2 | Operand class: 0 special, 1 global, 2 stack-relative |
| stackAddr | output | 16 | Address of the pushed or popped stack item |
| spValue | output | 16 | Current data stack pointer |

## Verification
Two pairs of functions can fall in the same cycle. A pop can meet a stack-relative operand, and a push or pop can meet a direct byte write. For the first pair, the bench drives a pop together with an offset selector and compares operandAddr against the pre-increment pointer and stackAddr against the incremented one, before the edge. For the second pair, it sweeps every stack code against every combination of byte writes from a known pointer. After the edge it checks each pointer byte against arithmetic expectations: the written data, the held byte, or pointer plus or minus one.

// File: rtl/sp_addr_pkg.sv
`timescale 1ns/1ps
package sp_addr_pkg;

  typedef enum logic [1:0] {
    SOP_NONE = 2'd0,
    SOP_PUSH = 2'd1,
    SOP_POP  = 2'd2,
    SOP_RSVD = 2'd3
  } stackOpE;

  typedef enum logic [1:0] {
    KIND_SPECIAL = 2'd0,
    KIND_GLOBAL  = 2'd1,
    KIND_STACK   = 2'd2,
    KIND_UNUSED  = 2'd3
  } kindE;

  // strobes from control to datapath
  typedef struct packed {
    logic incSp;      // pointer += 1 at edge
    logic decSp;      // pointer -= 1 at edge
    logic ldHi;       // load high byte
    logic ldLo;       // load low byte
    logic selOffset;  // operand = pointer + offset
    logic stackPre;   // stack item at pointer + 1
  } ctrlStrobeT;

endpackage

// File: rtl/sp_addr_ctrl.sv
`timescale 1ns/1ps
module sp_addr_ctrl
  import sp_addr_pkg::*;
(
  input  logic [1:0]  modeBits,   // selector bits {8,7}
  input  logic [1:0]  stackOp,
  input  logic        wrHi,
  input  logic        wrLo,
  output ctrlStrobeT  strb,
  output logic [1:0]  opKind
);

  stackOpE opCode;
  logic    anyWrite;
  logic    isPush;
  logic    isPop;

  always_comb begin
    opCode   = stackOpE'(stackOp);
    anyWrite = wrHi | wrLo;
    isPush   = (opCode == SOP_PUSH);
    isPop    = (opCode == SOP_POP);
  end

  always_comb begin
    strb           = '0;
    strb.ldHi      = wrHi;
    strb.ldLo      = wrLo;
    // a direct write suppresses the automatic update
    strb.incSp     = isPop  & ~anyWrite;
    strb.decSp     = isPush & ~anyWrite;
    strb.stackPre  = isPop;
    strb.selOffset = modeBits[1];
  end

  always_comb begin
    kindE k;
    if (modeBits[1])      k = KIND_STACK;
    else if (modeBits[0]) k = KIND_GLOBAL;
    else                  k = KIND_SPECIAL;
    opKind = k;
  end

endmodule

// File: rtl/sp_addr_dp.sv
`timescale 1ns/1ps
module sp_addr_dp
  import sp_addr_pkg::*;
#(
  parameter int BYTE_W  = 8,
  parameter int FIELD_W = 9,
  parameter int OFF_W   = 7,
  parameter logic [2*BYTE_W-1:0] RESET_SP = 16'h0FFF
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStrobeT         strb,
  input  logic [FIELD_W-2:0] lowField,
  input  logic [BYTE_W-1:0]  wrData,
  output logic [2*BYTE_W-1:0] operandAddr,
  output logic [2*BYTE_W-1:0] stackAddr,
  output logic [2*BYTE_W-1:0] spValue
);

  localparam int ADDR_W    = 2 * BYTE_W;
  localparam int NUM_BYTES = ADDR_W / BYTE_W;

  logic [ADDR_W-1:0] sp;
  logic [ADDR_W-1:0] spInc;
  logic [ADDR_W-1:0] spDec;
  logic [ADDR_W-1:0] spAuto;
  logic [ADDR_W-1:0] offAddr;
  logic [ADDR_W-1:0] directAddr;
  logic              anyLoad;

  always_comb begin
    spInc   = sp + ADDR_W'(1);
    spDec   = sp - ADDR_W'(1);
    anyLoad = strb.ldHi | strb.ldLo;
    if (strb.incSp)      spAuto = spInc;
    else if (strb.decSp) spAuto = spDec;
    else                 spAuto = sp;
  end

  // pointer byte registers
  for (genvar g = 0; g < NUM_BYTES; g++) begin : gByte
    logic [BYTE_W-1:0] byteQ;
    logic              byteLd;
    assign byteLd = (g == NUM_BYTES - 1) ? strb.ldHi : strb.ldLo;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)        byteQ <= RESET_SP[g*BYTE_W +: BYTE_W];
      else if (byteLd)  byteQ <= wrData;
      else if (!anyLoad) byteQ <= spAuto[g*BYTE_W +: BYTE_W];
    end
    assign sp[g*BYTE_W +: BYTE_W] = byteQ;
  end

  always_comb begin
    offAddr     = sp + ADDR_W'(lowField[OFF_W-1:0]);
    directAddr  = ADDR_W'(lowField);
    operandAddr = strb.selOffset ? offAddr : directAddr;
    stackAddr   = strb.stackPre ? spInc : sp;
    spValue     = sp;
  end

endmodule

// File: rtl/sp_operand_addr.sv
`timescale 1ns/1ps
module sp_operand_addr
  import sp_addr_pkg::*;
#(
  parameter int BYTE_W  = 8,
  parameter int FIELD_W = 9,
  parameter int OFF_W   = 7,
  parameter logic [2*BYTE_W-1:0] RESET_SP = 16'h0FFF
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [FIELD_W-1:0]  opField,
  input  logic [1:0]          stackOp,
  input  logic                wrHi,
  input  logic                wrLo,
  input  logic [BYTE_W-1:0]   wrData,
  output logic [2*BYTE_W-1:0] operandAddr,
  output logic [1:0]          opKind,
  output logic [2*BYTE_W-1:0] stackAddr,
  output logic [2*BYTE_W-1:0] spValue
);

  ctrlStrobeT strb;

  sp_addr_ctrl u_ctrl (
    .modeBits (opField[FIELD_W-1:FIELD_W-2]),
    .stackOp  (stackOp),
    .wrHi     (wrHi),
    .wrLo     (wrLo),
    .strb     (strb),
    .opKind   (opKind)
  );

  sp_addr_dp #(
    .BYTE_W   (BYTE_W),
    .FIELD_W  (FIELD_W),
    .OFF_W    (OFF_W),
    .RESET_SP (RESET_SP)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .lowField    (opField[FIELD_W-2:0]),
    .wrData      (wrData),
    .operandAddr (operandAddr),
    .stackAddr   (stackAddr),
    .spValue     (spValue)
  );

endmodule

// File: rtl/sp_operand_addr_chk.sv
`timescale 1ns/1ps
module sp_operand_addr_chk #(
  parameter int BYTE_W  = 8,
  parameter int FIELD_W = 9,
  parameter int OFF_W   = 7,
  parameter logic [2*BYTE_W-1:0] RESET_SP = 16'h0FFF
) (
  input logic                clk,
  input logic                rstN,
  input logic [FIELD_W-1:0]  opField,
  input logic [1:0]          stackOp,
  input logic                wrHi,
  input logic                wrLo,
  input logic [BYTE_W-1:0]   wrData,
  input logic [2*BYTE_W-1:0] operandAddr,
  input logic [1:0]          opKind,
  input logic [2*BYTE_W-1:0] stackAddr,
  input logic [2*BYTE_W-1:0] spValue
);
  localparam int ADDR_W = 2 * BYTE_W;

  // R1
  reset_value_chk: assert property (@(posedge clk) $rose(rstN) |-> spValue == RESET_SP);

  // R2
  special_direct_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!opField[FIELD_W-1] && !opField[FIELD_W-2]) |->
      (operandAddr == ADDR_W'(opField[OFF_W-1:0]) && opKind == 2'd0));

  // R4
  offset_sum_chk: assert property (@(posedge clk) disable iff (!rstN)
    opField[FIELD_W-1] |->
      (operandAddr == ADDR_W'(spValue + ADDR_W'(opField[OFF_W-1:0])) && opKind == 2'd2));

  // R5
  push_dec_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stackOp == 2'd1 && !wrHi && !wrLo) |=> spValue == ADDR_W'($past(spValue) - ADDR_W'(1)));

  // R6
  pop_inc_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stackOp == 2'd2 && !wrHi && !wrLo) |=> spValue == ADDR_W'($past(spValue) + ADDR_W'(1)));

  // R6
  pop_addr_chk: assert property (@(posedge clk) disable iff (!rstN)
    stackOp == 2'd2 |-> stackAddr == ADDR_W'(spValue + ADDR_W'(1)));

  // R7
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((stackOp == 2'd0 || stackOp == 2'd3) && !wrHi && !wrLo) |=> $stable(spValue));

  // R8
  wr_hi_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrHi |=> spValue[ADDR_W-1:BYTE_W] == $past(wrData));

  // R8
  wr_lo_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrLo |=> spValue[BYTE_W-1:0] == $past(wrData));

  // R9
  wr_block_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrHi && !wrLo) |=> spValue[BYTE_W-1:0] == $past(spValue[BYTE_W-1:0]));

endmodule

bind sp_operand_addr sp_operand_addr_chk #(
  .BYTE_W   (BYTE_W),
  .FIELD_W  (FIELD_W),
  .OFF_W    (OFF_W),
  .RESET_SP (RESET_SP)
) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .opField     (opField),
  .stackOp     (stackOp),
  .wrHi        (wrHi),
  .wrLo        (wrLo),
  .wrData      (wrData),
  .operandAddr (operandAddr),
  .opKind      (opKind),
  .stackAddr   (stackAddr),
  .spValue     (spValue)
);

// File: tb/sp_operand_addr_bench.sv
`timescale 1ns/1ps
module sp_operand_addr_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN;
  logic [8:0]  opField;
  logic [1:0]  stackOp;
  logic        wrHi, wrLo;
  logic [7:0]  wrData;
  logic [15:0] operandAddr, stackAddr, spValue;
  logic [1:0]  opKind;

  int checks = 0;
  int failures = 0;
  logic [15:0] model;

  sp_operand_addr u_sp_operand_addr (
    .clk(clk), .rstN(rstN), .opField(opField), .stackOp(stackOp),
    .wrHi(wrHi), .wrLo(wrLo), .wrData(wrData),
    .operandAddr(operandAddr), .opKind(opKind),
    .stackAddr(stackAddr), .spValue(spValue)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic loadSp(input logic [15:0] v);
    wrData = v[15:8]; wrHi = 1'b1; step(); wrHi = 1'b0;
    wrData = v[7:0];  wrLo = 1'b1; step(); wrLo = 1'b0;
    model = v;
    check("R8 load", {16'h0, spValue}, {16'h0, v});
  endtask

  task automatic sweepField(input logic [15:0] base);
    loadSp(base);
    for (int f = 0; f < 512; f++) begin
      logic [8:0]  fv;
      logic [15:0] eAddr;
      logic [1:0]  eKind;
      fv = 9'(f);
      opField = fv;
      #1;
      if (fv[8]) begin
        eAddr = 16'((32'(base) + 32'(fv[6:0])) % 32'h10000);
        eKind = 2'd2;
        check("R4 addr", {16'h0, operandAddr}, {16'h0, eAddr});
        check("R4 kind", {30'h0, opKind}, {30'h0, eKind});
      end else if (fv[7]) begin
        eAddr = 16'h0080 + 16'(fv[6:0]);
        check("R3 addr", {16'h0, operandAddr}, {16'h0, eAddr});
        check("R3 kind", {30'h0, opKind}, 32'd1);
      end else begin
        eAddr = 16'(fv[6:0]);
        check("R2 addr", {16'h0, operandAddr}, {16'h0, eAddr});
        check("R2 kind", {30'h0, opKind}, 32'd0);
      end
    end
    opField = 9'h0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rstN = 1'b0; opField = '0; stackOp = 2'd0; wrHi = 0; wrLo = 0; wrData = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 reset during", {16'h0, spValue}, 32'h0FFF);
    rstN = 1'b1;
    step();
    check("R1 reset after", {16'h0, spValue}, 32'h0FFF);

    // field sweeps at several pointers, including a wrapping sum (R4, R10)
    sweepField(16'h0FFF);
    sweepField(16'hFFC0);
    sweepField(16'h1234);

    // R6: pop with stack-relative operand in the same cycle
    loadSp(16'h0200);
    opField = 9'h105; stackOp = 2'd2;
    #1;
    check("R6 pre-inc operand", {16'h0, operandAddr}, 32'h0205);
    check("R6 stack addr", {16'h0, stackAddr}, 32'h0201);
    step();
    stackOp = 2'd0;
    check("R6 pointer", {16'h0, spValue}, 32'h0201);

    // R5: push with operand in the same cycle
    opField = 9'h17F; stackOp = 2'd1;
    #1;
    check("R5 operand", {16'h0, operandAddr}, 32'h0280);
    check("R5 stack addr", {16'h0, stackAddr}, 32'h0201);
    step();
    stackOp = 2'd0; opField = 9'h0;
    check("R5 pointer", {16'h0, spValue}, 32'h0200);

    // R10: wrap both directions
    loadSp(16'hFFFF);
    stackOp = 2'd2;
    #1;
    check("R10 pop stack addr", {16'h0, stackAddr}, 32'h0000);
    step();
    check("R10 pop wrap", {16'h0, spValue}, 32'h0000);
    stackOp = 2'd1;
    #1;
    check("R10 push stack addr", {16'h0, stackAddr}, 32'h0000);
    step();
    stackOp = 2'd0;
    check("R10 push wrap", {16'h0, spValue}, 32'hFFFF);

    // R9 / R7 / R8: every stack code against every write combination
    for (int op = 0; op < 4; op++) begin
      for (int wh = 0; wh < 2; wh++) begin
        for (int wl = 0; wl < 2; wl++) begin
          logic [15:0] exp;
          loadSp(16'h5A3C);
          stackOp = 2'(op); wrHi = 1'(wh); wrLo = 1'(wl); wrData = 8'hC3;
          #1;
          if (op == 2) check("R6 stack addr sweep", {16'h0, stackAddr}, 32'h5A3D);
          else         check("R7 stack addr sweep", {16'h0, stackAddr}, 32'h5A3C);
          step();
          stackOp = 2'd0; wrHi = 0; wrLo = 0;
          if (wh != 0 || wl != 0) begin
            exp = {(wh != 0) ? 8'hC3 : 8'h5A, (wl != 0) ? 8'hC3 : 8'h3C};
            check("R9 write wins", {16'h0, spValue}, {16'h0, exp});
          end else begin
            if (op == 1)      exp = 16'h5A3B;
            else if (op == 2) exp = 16'h5A3D;
            else              exp = 16'h5A3C;
            check("R7 no write", {16'h0, spValue}, {16'h0, exp});
          end
        end
      end
    end

    // long push/pop sequence against an arithmetic model (R5 R6 R7)
    loadSp(16'h0800);
    for (int i = 0; i < 400; i++) begin
      logic [1:0] op;
      op = 2'($urandom_range(0, 3));
      stackOp = op;
      #1;
      check("R5 R6 R7 seq stack addr", {16'h0, stackAddr},
            {16'h0, (op == 2'd2) ? 16'(model + 16'd1) : model});
      step();
      if (op == 2'd1)      model = model - 16'd1;
      else if (op == 2'd2) model = model + 16'd1;
      check("R5 R6 R7 seq pointer", {16'h0, spValue}, {16'h0, model});
    end
    stackOp = 2'd0;

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule